// File: doc/BRIEF.md
# Banked Memory-Map Address Router

This block sits between two bus masters, a processor and a block-copy engine, and the slave regions of a 16-bit-address, 8-bit-data console memory map. Every access is decoded in the same cycle it is presented. The block raises exactly one region select, hands that region a local address, and returns the region's read data to whichever master currently owns the bus. Slave storage, cartridge bank control and the video renderer sit outside the block. Video memory and the video control registers go out to a separate video unit over their own select.

The block holds two bank registers of its own. One picks which 4 KB work memory bank appears in the upper half of the work memory window. The other picks which of two video memory banks the video unit uses. Work memory is mirrored into an echo range through the same select. A small unusable hole answers reads with all ones and takes no writes. When the copy engine raises its request, it takes the bus and the processor is told to halt.

Top module: `mem_router`

## Requirements
- R1: While `dma_req` is 1 the copy engine's address, data and strobes drive the bus and `cpu_halt` is 1; while it is 0 the processor owns the bus and `cpu_halt` is 0. A strobe from the master that does not own the bus has no effect.
- R2: An access to 0x0000–0x7FFF asserts `cart_rom_cs`, and `cart_addr` carries the full address.
- R3: An access to 0x8000–0x9FFF, 0xFF40–0xFF4B or 0xFF68–0xFF6B asserts `vid_cs`, and `vid_addr` carries the full address.
- R4: An access to 0xA000–0xBFFF asserts `cart_ram_cs`, and `cart_addr` carries the full address.
- R5: An access to 0xC000–0xDFFF asserts `wram_cs`, and `wram_addr` is {bank, address[11:0]}. The bank is 0 when address bit 12 is 0. Otherwise it is the low 3 bits of the bank register at 0xFF70, with a stored 0 used as bank 1. After reset the stored value is 1.
- R6: An access to 0xE000–0xFDFF asserts `wram_cs` with the same `wram_addr` as the address 0x2000 lower.
- R7: An access to 0xFE00–0xFE9F asserts `oam_cs` with `oam_addr` equal to address[7:0]. An access to 0xFEA0–0xFEFF asserts no select and no bus strobe, and a read there returns 0xFF.
- R8: Any other access in 0xFF00–0xFF7F asserts `io_cs` with `io_addr` equal to address[6:0]. An access to 0xFF80–0xFFFE asserts `hram_cs` with `hram_addr` equal to address[6:0]. An access to 0xFFFF asserts `ie_cs`.
- R9: The video bank register at 0xFF4F stores write-data bit 0, drives `vid_bank`, resets to 0 and reads as {7'h7F, bank}. The work bank register at 0xFF70 stores write-data bits 2:0 and reads as {5'h1F, stored}. A write updates either register at the next rising clock edge, and neither register raises a select or bus strobe.
- R10: The owning master receives the selected region's read data in the same cycle while its read strobe is low. The other master, and any master that is not reading, receives 0xFF.
- R11: All strobes are active low. `bus_rd_n` and `bus_wr_n` fall only while the owning master strobes an external region, and with no strobe active every select is 0. `bus_wdata` always carries the owning master's write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rd_n | input | 1 | Processor read strobe, active low |
| cpu_wr_n | input | 1 | Processor write strobe, active low |
| cpu_rdata | output | 8 | Read data to processor |
| cpu_halt | output | 1 | Processor halt while the copy engine owns the bus |
| dma_req | input | 1 | Copy engine bus request |
| dma_addr | input | 16 | Copy engine address |
| dma_wdata | input | 8 | Copy engine write data |
| dma_rd_n | input | 1 | Copy engine read strobe, active low |
| dma_wr_n | input | 1 | Copy engine write strobe, active low |
| dma_rdata | output | 8 | Read data to copy engine |
| bus_wdata | output | 8 | Write data to all regions |
| bus_rd_n | output | 1 | Region read strobe, active low |
| bus_wr_n | output | 1 | Region write strobe, active low |
| cart_rom_cs | output | 1 | Cartridge program memory select |
| cart_ram_cs | output | 1 | Cartridge external memory select |
| cart_addr | output | 16 | Cartridge address |
| cart_rdata | input | 8 | Cartridge read data |
| vid_cs | output | 1 | Video unit select |
| vid_addr | output | 16 | Video unit address |
| vid_bank | output | 1 | Video memory bank |
| vid_rdata | input | 8 | Video unit read data |
| wram_cs | output | 1 | Work memory select |
| wram_addr | output | 15 | Work memory address, bank and offset |
| wram_rdata | input | 8 | Work memory read data |
| oam_cs | output | 1 | Sprite attribute memory select |
| oam_addr | output | 8 | Sprite attribute memory address |
| oam_rdata | input | 8 | Sprite attribute memory read data |
| io_cs | output | 1 | I/O register select |
| io_addr | output | 7 | I/O register address |
| io_rdata | input | 8 | I/O register read data |
| hram_cs | output | 1 | High memory select |
| hram_addr | output | 7 | High memory address |
| hram_rdata | input | 8 | High memory read data |
| ie_cs | output | 1 | Interrupt-enable register select |
| ie_rdata | input | 8 | Interrupt-enable register read data |

## Verification
Decode, selects, local addresses, strobes and read data are combinational, so each result is due in the cycle its stimulus is applied. The bench changes inputs on the falling edge and compares against its model 1 ns later, before the next rising edge. A write to either bank register takes effect at the next rising edge. The model applies its own bank update only after that cycle's comparison, so the following access is the first one to see the new bank, which matches the register in the design.

// File: rtl/mr_pkg.sv
package mr_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int WBANK_W = 3;
  localparam int WOFS_W = 12;
  localparam int OAM_W = 8;
  localparam int HIO_W = 7;

  typedef enum logic [3:0] {
    TGT_NONE, TGT_ROM, TGT_CRAM, TGT_VID, TGT_WRAM, TGT_OAM,
    TGT_IO, TGT_HRAM, TGT_IE, TGT_VBANK, TGT_WBANK
  } tgt_e;

  localparam logic [15:0] VID_BASE = 16'h8000;
  localparam logic [15:0] CRAM_BASE = 16'hA000;
  localparam logic [15:0] WRAM_BASE = 16'hC000;
  localparam logic [15:0] OAM_BASE = 16'hFE00;
  localparam logic [15:0] HOLE_BASE = 16'hFEA0;
  localparam logic [15:0] IO_BASE = 16'hFF00;
  localparam logic [15:0] HRAM_BASE = 16'hFF80;
  localparam logic [15:0] IE_ADDR = 16'hFFFF;
  localparam logic [15:0] VBANK_ADDR = 16'hFF4F;
  localparam logic [15:0] WBANK_ADDR = 16'hFF70;
  localparam logic [15:0] LCDREG_LO = 16'hFF40;
  localparam logic [15:0] LCDREG_HI = 16'hFF4B;
  localparam logic [15:0] PALREG_LO = 16'hFF68;
  localparam logic [15:0] PALREG_HI = 16'hFF6B;
endpackage

// File: rtl/mr_master_sel.sv
module mr_master_sel #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          dma_req,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          cpu_rd_n,
  input  logic          cpu_wr_n,
  input  logic [AW-1:0] dma_addr,
  input  logic [DW-1:0] dma_wdata,
  input  logic          dma_rd_n,
  input  logic          dma_wr_n,
  input  logic [DW-1:0] rdata,
  output logic [AW-1:0] act_addr,
  output logic [DW-1:0] act_wdata,
  output logic          act_rd,
  output logic          act_wr,
  output logic [DW-1:0] cpu_rdata,
  output logic [DW-1:0] dma_rdata,
  output logic          cpu_halt
);
  localparam logic [DW-1:0] IDLE_DATA = '1;

  always_comb begin
    if (dma_req) begin
      act_addr  = dma_addr;
      act_wdata = dma_wdata;
      act_rd    = ~dma_rd_n;
      act_wr    = ~dma_wr_n;
    end else begin
      act_addr  = cpu_addr;
      act_wdata = cpu_wdata;
      act_rd    = ~cpu_rd_n;
      act_wr    = ~cpu_wr_n;
    end
  end

  always_comb begin
    cpu_rdata = IDLE_DATA;
    dma_rdata = IDLE_DATA;
    if (act_rd) begin
      if (dma_req) dma_rdata = rdata;
      else         cpu_rdata = rdata;
    end
  end

  assign cpu_halt = dma_req;
endmodule

// File: rtl/mr_decode.sv
module mr_decode
  import mr_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0] addr,
  input  logic          rd,
  input  logic          wr,
  output tgt_e          tgt,
  output logic          ext_hit
);
  logic in_vid_regs;

  assign in_vid_regs = ((addr >= LCDREG_LO) && (addr <= LCDREG_HI)) ||
                       ((addr >= PALREG_LO) && (addr <= PALREG_HI));

  always_comb begin
    tgt = TGT_NONE;
    if (rd || wr) begin
      if (addr < VID_BASE)                    tgt = TGT_ROM;
      else if (addr < CRAM_BASE)              tgt = TGT_VID;
      else if (addr < WRAM_BASE)              tgt = TGT_CRAM;
      else if (addr < OAM_BASE)               tgt = TGT_WRAM;
      else if (addr < HOLE_BASE)              tgt = TGT_OAM;
      else if (addr < IO_BASE)                tgt = TGT_NONE;
      else if (addr == VBANK_ADDR)            tgt = TGT_VBANK;
      else if (addr == WBANK_ADDR)            tgt = TGT_WBANK;
      else if (in_vid_regs)                   tgt = TGT_VID;
      else if (addr < HRAM_BASE)              tgt = TGT_IO;
      else if (addr < IE_ADDR)                tgt = TGT_HRAM;
      else                                    tgt = TGT_IE;
    end
  end

  assign ext_hit = (tgt != TGT_NONE) && (tgt != TGT_VBANK) && (tgt != TGT_WBANK);
endmodule

// File: rtl/mr_bank_regs.sv
module mr_bank_regs #(
  parameter int WBW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rst_n_s,
  input  logic           vbank_we,
  input  logic           vbank_wd,
  input  logic           wbank_we,
  input  logic [WBW-1:0] wbank_wd,
  output logic           vbank,
  output logic [WBW-1:0] wbank_raw,
  output logic [WBW-1:0] wbank_eff
);
  localparam logic [WBW-1:0] WB_RESET = WBW'(1);

  logic           vbank_q, vbank_d;
  logic [WBW-1:0] wbank_q, wbank_d;

  always_comb begin
    vbank_d = vbank_q;
    wbank_d = wbank_q;
    if (vbank_we) vbank_d = vbank_wd;
    if (wbank_we) wbank_d = wbank_wd;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      vbank_q <= 1'b0;
      wbank_q <= WB_RESET;
    end else begin
      if (vbank_we) vbank_q <= vbank_d;
      if (wbank_we) wbank_q <= wbank_d;
    end
  end

  assign vbank     = vbank_q;
  assign wbank_raw = wbank_q;
  assign wbank_eff = (wbank_q == '0) ? WB_RESET : wbank_q;

  AST_WBANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wbank_we |=> $stable(wbank_q)) else $error("work bank moved"); // R9
  AST_VBANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !vbank_we |=> $stable(vbank_q)) else $error("video bank moved"); // R9
endmodule

// File: rtl/mr_read_mux.sv
module mr_read_mux
  import mr_pkg::*;
#(
  parameter int DW = 8,
  parameter int WBW = 3
) (
  input  tgt_e           tgt,
  input  logic [DW-1:0]  cart_rdata,
  input  logic [DW-1:0]  vid_rdata,
  input  logic [DW-1:0]  wram_rdata,
  input  logic [DW-1:0]  oam_rdata,
  input  logic [DW-1:0]  io_rdata,
  input  logic [DW-1:0]  hram_rdata,
  input  logic [DW-1:0]  ie_rdata,
  input  logic           vbank,
  input  logic [WBW-1:0] wbank_raw,
  output logic [DW-1:0]  rdata
);
  always_comb begin
    rdata = '1;
    unique case (tgt)
      TGT_ROM, TGT_CRAM: rdata = cart_rdata;
      TGT_VID:           rdata = vid_rdata;
      TGT_WRAM:          rdata = wram_rdata;
      TGT_OAM:           rdata = oam_rdata;
      TGT_IO:            rdata = io_rdata;
      TGT_HRAM:          rdata = hram_rdata;
      TGT_IE:            rdata = ie_rdata;
      TGT_VBANK:         rdata = {{(DW-1){1'b1}}, vbank};
      TGT_WBANK:         rdata = {{(DW-WBW){1'b1}}, wbank_raw};
      default:           rdata = '1;
    endcase
  end
endmodule

// File: rtl/mem_router.sv
module mem_router
  import mr_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic [DATA_W-1:0]   cpu_wdata,
  input  logic                cpu_rd_n,
  input  logic                cpu_wr_n,
  output logic [DATA_W-1:0]   cpu_rdata,
  output logic                cpu_halt,
  input  logic                dma_req,
  input  logic [ADDR_W-1:0]   dma_addr,
  input  logic [DATA_W-1:0]   dma_wdata,
  input  logic                dma_rd_n,
  input  logic                dma_wr_n,
  output logic [DATA_W-1:0]   dma_rdata,
  output logic [DATA_W-1:0]   bus_wdata,
  output logic                bus_rd_n,
  output logic                bus_wr_n,
  output logic                cart_rom_cs,
  output logic                cart_ram_cs,
  output logic [ADDR_W-1:0]   cart_addr,
  input  logic [DATA_W-1:0]   cart_rdata,
  output logic                vid_cs,
  output logic [ADDR_W-1:0]   vid_addr,
  output logic                vid_bank,
  input  logic [DATA_W-1:0]   vid_rdata,
  output logic                wram_cs,
  output logic [WBANK_W+WOFS_W-1:0] wram_addr,
  input  logic [DATA_W-1:0]   wram_rdata,
  output logic                oam_cs,
  output logic [OAM_W-1:0]    oam_addr,
  input  logic [DATA_W-1:0]   oam_rdata,
  output logic                io_cs,
  output logic [HIO_W-1:0]    io_addr,
  input  logic [DATA_W-1:0]   io_rdata,
  output logic                hram_cs,
  output logic [HIO_W-1:0]    hram_addr,
  input  logic [DATA_W-1:0]   hram_rdata,
  output logic                ie_cs,
  input  logic [DATA_W-1:0]   ie_rdata
);
  localparam int SYNC_D = 2;

  logic [SYNC_D-1:0]  rst_pipe;
  logic               rst_n_s;
  logic [ADDR_W-1:0]  act_addr;
  logic [DATA_W-1:0]  act_wdata;
  logic               act_rd, act_wr;
  logic [DATA_W-1:0]  rdata;
  tgt_e               tgt;
  logic               ext_hit;
  logic               vbank;
  logic [WBANK_W-1:0] wbank_raw, wbank_eff, wsel;
  logic               in_hole;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_D-2:0], 1'b1};
  end
  assign rst_n_s = rst_pipe[SYNC_D-1];

  mr_master_sel #(.AW(ADDR_W), .DW(DATA_W)) u_msel (
    .dma_req(dma_req), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd_n(cpu_rd_n), .cpu_wr_n(cpu_wr_n), .dma_addr(dma_addr),
    .dma_wdata(dma_wdata), .dma_rd_n(dma_rd_n), .dma_wr_n(dma_wr_n),
    .rdata(rdata), .act_addr(act_addr), .act_wdata(act_wdata),
    .act_rd(act_rd), .act_wr(act_wr), .cpu_rdata(cpu_rdata),
    .dma_rdata(dma_rdata), .cpu_halt(cpu_halt)
  );

  mr_decode #(.AW(ADDR_W)) u_dec (
    .addr(act_addr), .rd(act_rd), .wr(act_wr), .tgt(tgt), .ext_hit(ext_hit)
  );

  mr_bank_regs #(.WBW(WBANK_W)) u_banks (
    .clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s),
    .vbank_we(act_wr && (tgt == TGT_VBANK)), .vbank_wd(act_wdata[0]),
    .wbank_we(act_wr && (tgt == TGT_WBANK)), .wbank_wd(act_wdata[WBANK_W-1:0]),
    .vbank(vbank), .wbank_raw(wbank_raw), .wbank_eff(wbank_eff)
  );

  mr_read_mux #(.DW(DATA_W), .WBW(WBANK_W)) u_rmux (
    .tgt(tgt), .cart_rdata(cart_rdata), .vid_rdata(vid_rdata),
    .wram_rdata(wram_rdata), .oam_rdata(oam_rdata), .io_rdata(io_rdata),
    .hram_rdata(hram_rdata), .ie_rdata(ie_rdata), .vbank(vbank),
    .wbank_raw(wbank_raw), .rdata(rdata)
  );

  // Address bit 12 splits the fixed bank from the window in both the
  // primary range and its echo, so the mirror needs no subtraction.
  assign wsel = act_addr[WOFS_W] ? wbank_eff : '0;

  assign bus_wdata   = act_wdata;
  assign bus_rd_n    = ~(act_rd && ext_hit);
  assign bus_wr_n    = ~(act_wr && ext_hit);
  assign cart_rom_cs = (tgt == TGT_ROM);
  assign cart_ram_cs = (tgt == TGT_CRAM);
  assign cart_addr   = act_addr;
  assign vid_cs      = (tgt == TGT_VID);
  assign vid_addr    = act_addr;
  assign vid_bank    = vbank;
  assign wram_cs     = (tgt == TGT_WRAM);
  assign wram_addr   = {wsel, act_addr[WOFS_W-1:0]};
  assign oam_cs      = (tgt == TGT_OAM);
  assign oam_addr    = act_addr[OAM_W-1:0];
  assign io_cs       = (tgt == TGT_IO);
  assign io_addr     = act_addr[HIO_W-1:0];
  assign hram_cs     = (tgt == TGT_HRAM);
  assign hram_addr   = act_addr[HIO_W-1:0];
  assign ie_cs       = (tgt == TGT_IE);

  assign in_hole = (act_addr >= HOLE_BASE) && (act_addr < IO_BASE);

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cart_rom_cs, cart_ram_cs, vid_cs, wram_cs, oam_cs, io_cs, hram_cs, ie_cs}))
    else $error("several selects"); // R8
  AST_HOLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (act_rd && in_hole) |-> (bus_rd_n && bus_wr_n && (dma_req ? dma_rdata : cpu_rdata) == 8'hFF))
    else $error("hole answered"); // R7
  AST_NO_CROSS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> (cpu_rdata == 8'hFF && cpu_halt)) else $error("cpu fed during dma"); // R10
  AST_WINDOW_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wram_cs && act_addr[WOFS_W]) |-> (wram_addr[WBANK_W+WOFS_W-1:WOFS_W] != '0))
    else $error("window bank zero"); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_rd && !act_wr) |-> (bus_rd_n && bus_wr_n && !wram_cs && !cart_rom_cs && !vid_cs))
    else $error("idle strobe"); // R11
endmodule

// File: tb/mem_router_tb_top.sv
`timescale 1ns/1ps
module mem_router_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [15:0] cpu_addr = '0, dma_addr = '0;
  logic [7:0]  cpu_wdata = '0, dma_wdata = '0;
  logic cpu_rd_n = 1'b1, cpu_wr_n = 1'b1, dma_rd_n = 1'b1, dma_wr_n = 1'b1, dma_req = 1'b0;
  logic [7:0] cpu_rdata, dma_rdata, bus_wdata;
  logic cpu_halt, bus_rd_n, bus_wr_n;
  logic cart_rom_cs, cart_ram_cs, vid_cs, vid_bank, wram_cs, oam_cs, io_cs, hram_cs, ie_cs;
  logic [15:0] cart_addr, vid_addr;
  logic [14:0] wram_addr;
  logic [7:0]  oam_addr;
  logic [6:0]  io_addr, hram_addr;
  localparam logic [7:0] D_CART = 8'hC1, D_VID = 8'h5A, D_WRAM = 8'h3C,
    D_OAM = 8'h0A, D_IO = 8'h10, D_HRAM = 8'h80, D_IE = 8'h1E;

  mem_router dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd_n(cpu_rd_n), .cpu_wr_n(cpu_wr_n), .cpu_rdata(cpu_rdata), .cpu_halt(cpu_halt),
    .dma_req(dma_req), .dma_addr(dma_addr), .dma_wdata(dma_wdata), .dma_rd_n(dma_rd_n),
    .dma_wr_n(dma_wr_n), .dma_rdata(dma_rdata), .bus_wdata(bus_wdata),
    .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .cart_rom_cs(cart_rom_cs),
    .cart_ram_cs(cart_ram_cs), .cart_addr(cart_addr), .cart_rdata(D_CART),
    .vid_cs(vid_cs), .vid_addr(vid_addr), .vid_bank(vid_bank), .vid_rdata(D_VID),
    .wram_cs(wram_cs), .wram_addr(wram_addr), .wram_rdata(D_WRAM),
    .oam_cs(oam_cs), .oam_addr(oam_addr), .oam_rdata(D_OAM),
    .io_cs(io_cs), .io_addr(io_addr), .io_rdata(D_IO),
    .hram_cs(hram_cs), .hram_addr(hram_addr), .hram_rdata(D_HRAM),
    .ie_cs(ie_cs), .ie_rdata(D_IE)
  );

  int checks = 0, errors = 0;
  int m_wbank = 1;  // model of stored work bank
  int m_vbank = 0;  // model of video bank

  // Region codes: 0 none,1 rom,2 cram,3 vid,4 wram,5 oam,6 io,7 hram,8 ie,9 vbank,10 wbank
  function automatic int region(input int a);
    if (a <= 16'h7FFF) return 1;
    if (a <= 16'h9FFF) return 3;
    if (a <= 16'hBFFF) return 2;
    if (a <= 16'hFDFF) return 4;
    if (a <= 16'hFE9F) return 5;
    if (a <= 16'hFEFF) return 0;
    if (a == 16'hFF4F) return 9;
    if (a == 16'hFF70) return 10;
    if ((a >= 16'hFF40 && a <= 16'hFF4B) || (a >= 16'hFF68 && a <= 16'hFF6B)) return 3;
    if (a <= 16'hFF7F) return 6;
    if (a <= 16'hFFFE) return 7;
    return 8;
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // One bus cycle: drive at falling edge, compare 1 ns later, update model afterwards.
  task automatic access(input string req, input bit use_dma, input int a,
                        input bit rd, input bit wr, input logic [7:0] wd,
                        input bit other_rd = 0, input bit other_wr = 0, input int other_a = 0);
    int r, wb, off;
    logic [7:0] cs_e, cs_g, rdv, crd, drd;
    logic [15:0] ra_e, ra_g;
    logic ext;
    @(negedge clk);
    dma_req = use_dma;
    if (use_dma) begin
      dma_addr = 16'(a); dma_wdata = wd; dma_rd_n = ~rd; dma_wr_n = ~wr;
      cpu_addr = 16'(other_a); cpu_wdata = ~wd; cpu_rd_n = ~other_rd; cpu_wr_n = ~other_wr;
    end else begin
      cpu_addr = 16'(a); cpu_wdata = wd; cpu_rd_n = ~rd; cpu_wr_n = ~wr;
      dma_addr = 16'(other_a); dma_wdata = ~wd; dma_rd_n = ~other_rd; dma_wr_n = ~other_wr;
    end
    #1;
    r = (rd || wr) ? region(a) : 0;
    cs_e = '0; ra_e = '0; rdv = 8'hFF;
    case (r)
      1: begin cs_e[7] = 1; ra_e = 16'(a); rdv = D_CART; end
      2: begin cs_e[6] = 1; ra_e = 16'(a); rdv = D_CART; end
      3: begin cs_e[5] = 1; ra_e = 16'(a); rdv = D_VID; end
      4: begin
           cs_e[4] = 1; off = (a >= 16'hE000) ? a - 16'h2000 : a;
           wb = (off >= 16'hD000) ? ((m_wbank == 0) ? 1 : m_wbank) : 0;
           ra_e = 16'(wb * 4096 + (off % 4096)); rdv = D_WRAM;
         end
      5: begin cs_e[3] = 1; ra_e = 16'(a % 256); rdv = D_OAM; end
      6: begin cs_e[2] = 1; ra_e = 16'(a % 128); rdv = D_IO; end
      7: begin cs_e[1] = 1; ra_e = 16'(a % 128); rdv = D_HRAM; end
      8: begin cs_e[0] = 1; rdv = D_IE; end
      9: rdv = 8'hFE | 8'(m_vbank);
      10: rdv = 8'hF8 | 8'(m_wbank);
      default: ;
    endcase
    ext = (r >= 1 && r <= 8);
    crd = (!use_dma && rd) ? rdv : 8'hFF;
    drd = (use_dma && rd) ? rdv : 8'hFF;
    cs_g = {cart_rom_cs, cart_ram_cs, vid_cs, wram_cs, oam_cs, io_cs, hram_cs, ie_cs};
    case (r)
      1, 2: ra_g = cart_addr;
      3: ra_g = vid_addr;
      4: ra_g = {1'b0, wram_addr};
      5: ra_g = {8'h00, oam_addr};
      6: ra_g = {9'h000, io_addr};
      7: ra_g = {9'h000, hram_addr};
      default: ra_g = '0;
    endcase
    check(req,
      {cs_g, ra_g, cpu_rdata, dma_rdata, cpu_halt, bus_rd_n, bus_wr_n, vid_bank, bus_wdata, 12'h0},
      {cs_e, ra_e, crd, drd, use_dma, ~(rd && ext), ~(wr && ext), 1'(m_vbank), wd, 12'h0});
    if (wr && r == 9)  m_vbank = int'(wd[0]);
    if (wr && r == 10) m_wbank = int'(wd[2:0]);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    // Reset state: idle bus, bank reset values (R11, R9, R5)
    access("R11 idle after reset", 0, 16'h1234, 0, 0, 8'h00);
    access("R5 reset window bank", 0, 16'hD456, 1, 0, 8'h00);
    access("R9 reset work bank readback", 0, 16'hFF70, 1, 0, 8'h00);
    access("R9 reset video bank readback", 0, 16'hFF4F, 1, 0, 8'h00);
    // Cartridge program (R2)
    access("R2 rom low", 0, 16'h0000, 1, 0, 8'h00);
    access("R2 rom top of fixed", 0, 16'h3FFF, 1, 0, 8'h00);
    access("R2 rom switchable", 0, 16'h4000, 1, 0, 8'h00);
    access("R2 rom end", 0, 16'h7FFF, 0, 1, 8'h21);
    // Video (R3)
    access("R3 vram", 0, 16'h8123, 1, 0, 8'h00);
    access("R3 vram end", 0, 16'h9FFF, 0, 1, 8'h44);
    access("R3 lcd reg lo", 0, 16'hFF40, 1, 0, 8'h00);
    access("R3 lcd reg hi", 0, 16'hFF4B, 1, 0, 8'h00);
    access("R3 palette reg", 0, 16'hFF68, 0, 1, 8'h07);
    access("R8 just past video regs", 0, 16'hFF4C, 1, 0, 8'h00);
    // Cartridge external memory (R4)
    access("R4 cart ram lo", 0, 16'hA000, 1, 0, 8'h00);
    access("R4 cart ram hi", 0, 16'hBFFF, 0, 1, 8'h99);
    // Work memory banks (R5, R9)
    access("R5 fixed bank", 0, 16'hC123, 1, 0, 8'h00);
    access("R9 write work bank 5", 0, 16'hFF70, 0, 1, 8'h05);
    access("R5 window bank 5", 0, 16'hD456, 1, 0, 8'h00);
    access("R5 fixed unaffected", 0, 16'hCFFF, 1, 0, 8'h00);
    access("R9 write work bank 0", 0, 16'hFF70, 0, 1, 8'h00);
    access("R5 stored zero maps to 1", 0, 16'hDFFF, 1, 0, 8'h00);
    access("R9 readback zero", 0, 16'hFF70, 1, 0, 8'h00);
    access("R9 write work bank 0xFF", 0, 16'hFF70, 0, 1, 8'hFF);
    access("R9 readback seven", 0, 16'hFF70, 1, 0, 8'h00);
    access("R5 window bank 7", 0, 16'hD000, 1, 0, 8'h00);
    // Echo (R6)
    access("R6 echo fixed", 0, 16'hE123, 1, 0, 8'h00);
    access("R6 echo window", 0, 16'hF456, 0, 1, 8'h3A);
    access("R6 echo end", 0, 16'hFDFF, 1, 0, 8'h00);
    // Sprite memory and hole (R7)
    access("R7 oam lo", 0, 16'hFE00, 1, 0, 8'h00);
    access("R7 oam hi", 0, 16'hFE9F, 1, 0, 8'h00);
    access("R7 hole read", 0, 16'hFEA0, 1, 0, 8'h00);
    access("R7 hole write ignored", 0, 16'hFEFF, 0, 1, 8'h12);
    // I/O, high memory, interrupt enable (R8)
    access("R8 io lo", 0, 16'hFF00, 1, 0, 8'h00);
    access("R8 io hi", 0, 16'hFF7F, 0, 1, 8'h01);
    access("R8 hram lo", 0, 16'hFF80, 1, 0, 8'h00);
    access("R8 hram hi", 0, 16'hFFFE, 1, 0, 8'h00);
    access("R8 ie", 0, 16'hFFFF, 1, 0, 8'h00);
    // Video bank register (R9)
    access("R9 write video bank 1", 0, 16'hFF4F, 0, 1, 8'h01);
    access("R9 video bank readback 1", 0, 16'hFF4F, 1, 0, 8'h00);
    access("R9 write video bank even", 0, 16'hFF4F, 0, 1, 8'h02);
    access("R9 video bank readback 0", 0, 16'hFF4F, 1, 0, 8'h00);
    // Copy engine ownership (R1, R10)
    access("R1 dma read while cpu reads", 1, 16'hC010, 1, 0, 8'h00, 1, 0, 16'h8000);
    access("R1 dma writes work bank", 1, 16'hFF70, 0, 1, 8'h03, 0, 0, 16'h0000);
    access("R1 cpu write ignored under dma", 1, 16'hFE00, 1, 0, 8'h00, 0, 1, 16'hFF70);
    access("R10 window after dma bank write", 0, 16'hD100, 1, 0, 8'h00, 1, 0, 16'h4000);
    access("R10 cpu not reading gets FF", 0, 16'hFF80, 0, 1, 8'h55, 1, 0, 16'h0000);
    access("R11 dma idle strobes", 1, 16'h0100, 0, 0, 8'h66, 1, 1, 16'h0100);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule